// File: doc/BRIEF.md
# ISA 16-bit Zero-Wait Memory Slave Front End

This block is the card-side logic of a 16-bit memory device on the ISA bus. It is built to finish accesses without wait states. It runs on a clock at twice the bus clock rate. All bus inputs are synchronous to that clock. Active-low bus lines appear as ports ending in `_n`.

While the address-latch-enable strobe is high, the block compares the unlatched upper address lines against a parameterised window. The result goes out at once on the 16-bit-capable line. The same clock that sees the strobe high also registers the decode result, the low address and the byte-high-enable. When the strobe falls, the registers hold, so a pipelined address for the next cycle cannot deselect the device.

During a selected command, the block does one of two things:
- It requests a zero-wait finish, when the local logic is ready.
- It pulls the channel-ready line low, when the local logic is not ready.

Reads drive the data lanes of a small internal word store, one lane enable per byte. Writes land in that store when the write command ends, byte by byte.

Top module: `isa_m16_slave`

## Requirements
- R1: After reset, `m16_n`, `nows_n` and `chrdy` are 1, `sd_oe` is 2'b00, and every word of the store reads as 16'h0000.
- R2: While `bale` is 1, `m16_n` is 0 in the same cycle exactly when `(la_hi & LA_MASK) == (LA_BASE & LA_MASK)`. The defaults are base 7'h05 and mask 7'h7F, which is the window 0x0A0000 to 0x0BFFFF.
- R3: The select is registered on each clock edge where `bale` is 1 and held while `bale` is 0. While `bale` is 0, `m16_n` shows the held select, and changes on `la_hi` have no effect.
- R4: `sa` and `sbhe_n` are registered on the same edges as the select. While `bale` is 0, changes on them do not alter which word or which bytes an access uses. The word index is `sa[IW:1]`, with IW = log2(DEPTH).
- R5: With ZERO_WAIT=1, `nows_n` is 0 exactly when the device is selected, a command (`mrdc_n` or `mwtc_n` at 0) is active and `lcl_rdy` is 1. At all other times `nows_n` is 1.
- R6: `chrdy` is 0 exactly when the device is selected, a command is active and `lcl_rdy` is 0. It returns to 1 in the same cycle that `lcl_rdy` rises.
- R7: While selected with `mrdc_n` at 0:
  - `sd_oe[0]` is 1 when latched SA0 is 0.
  - `sd_oe[1]` is 1 when the latched `sbhe_n` is 0.
  - `sd_out` carries the addressed word.
  - Otherwise `sd_oe` is 2'b00.
- R8: A write is taken on the first clock edge where `mwtc_n` is 1 after a cycle where it was 0, while selected. The data comes from `sd_in` at that edge.
- R9: When the select is not set, no command changes the store, `sd_oe` stays 2'b00 and `chrdy` and `nows_n` stay 1.
- R10: A write changes only the enabled bytes. Bits [7:0] are written when SA0 is 0, and bits [15:8] are written when `sbhe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low reset |
| la_hi | input | 7 | Unlatched upper address bits 23..17 |
| sa | input | 20 | Latched system address bits 19..0 |
| sbhe_n | input | 1 | Byte-high enable, active low |
| bale | input | 1 | Address latch enable |
| mrdc_n | input | 1 | Memory read command, active low |
| mwtc_n | input | 1 | Memory write command, active low |
| sd_in | input | 16 | Data bus as seen by the card |
| lcl_rdy | input | 1 | Local logic can finish the access |
| sd_out | output | 16 | Read data toward the bus |
| sd_oe | output | 2 | Per-lane read drive enables (bit 1 = high byte) |
| m16_n | output | 1 | 16-bit capable, active low |
| nows_n | output | 1 | Zero-wait request, active low |
| chrdy | output | 1 | Channel ready; 0 inserts wait states |

## Verification
The outputs `m16_n`, `nows_n`, `chrdy`, `sd_oe` and `sd_out` are combinational from the inputs and the latched select. The bench drives inputs at the falling clock edge and checks them two time units later, in the same half cycle. The latched select and address take effect one rising edge after `bale` is sampled high. Because of this, the checks after `bale` falls also change `la_hi` and `sa` to make sure the held values are used. A write lands on the rising edge that first sees `mwtc_n` high again, so it is checked by a later read cycle and never in the cycle of the write.

// File: rtl/isa_m16_pkg.sv
package isa_m16_pkg;
   localparam int LA_W = 7;
   localparam int SA_W = 20;
   localparam int DW   = 16;

   typedef struct packed {
      logic            cs;
      logic            sbhe_n;
      logic [SA_W-1:0] sa;
   } addr_cap_t;

   function automatic logic la_hit(input logic [LA_W-1:0] la,
                                   input logic [LA_W-1:0] base,
                                   input logic [LA_W-1:0] mask);
      return (la & mask) == (base & mask);
   endfunction
endpackage

// File: rtl/isa_m16_decode.sv
module isa_m16_decode
   import isa_m16_pkg::*;
#(
   parameter logic [LA_W-1:0] LA_BASE = 7'h05,
   parameter logic [LA_W-1:0] LA_MASK = 7'h7F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LA_W-1:0] la_hi,
   input  logic [SA_W-1:0] sa,
   input  logic            sbhe_n,
   input  logic            bale,
   output addr_cap_t       cap,
   output logic            m16_n
);
   logic hit;

   assign hit = la_hit(la_hi, LA_BASE, LA_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cap <= '0;
      else if (bale) cap <= '{cs: hit, sbhe_n: sbhe_n, sa: sa};
   end

   assign m16_n = bale ? ~hit : ~cap.cs;

   // R3
   hold_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bale && $past(!bale)) |-> $stable(cap));
endmodule

// File: rtl/isa_m16_handshake.sv
module isa_m16_handshake #(
   parameter bit ZERO_WAIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic mrdc_n,
   input  logic mwtc_n,
   input  logic lcl_rdy,
   output logic nows_n,
   output logic chrdy
);
   logic cmd_act;

   assign cmd_act = cs && (!mrdc_n || !mwtc_n);
   assign chrdy   = !(cmd_act && !lcl_rdy);

   if (ZERO_WAIT) begin : g_fast
      assign nows_n = !(cmd_act && lcl_rdy);
   end else begin : g_std
      assign nows_n = 1'b1;
   end

   // R6
   wait_only_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chrdy |-> (cs && (!mrdc_n || !mwtc_n)));
   // R5
   nows_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nows_n |-> chrdy);
endmodule

// File: rtl/isa_m16_store.sv
module isa_m16_store
   import isa_m16_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  addr_cap_t     cap,
   input  logic          mrdc_n,
   input  logic          mwtc_n,
   input  logic [DW-1:0] sd_in,
   output logic [DW-1:0] sd_out,
   output logic [1:0]    sd_oe
);
   localparam int IW = $clog2(DEPTH);
   localparam int NL = DW / 8;

   logic [DEPTH-1:0][DW-1:0] mem;
   logic                     mwtc_q;
   logic                     wr_fire;
   logic [IW-1:0]            idx;
   logic [NL-1:0]            lane_en;

   assign idx        = cap.sa[IW:1];
   assign lane_en[0] = ~cap.sa[0];
   assign lane_en[1] = ~cap.sbhe_n;
   assign wr_fire    = cap.cs && !mwtc_q && mwtc_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mwtc_q <= 1'b1;
      else        mwtc_q <= mwtc_n;
   end

   for (genvar l = 0; l < NL; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w][8*l +: 8] <= '0;
         end else if (wr_fire && lane_en[l]) begin
            mem[idx][8*l +: 8] <= sd_in[8*l +: 8];
         end
      end
      assign sd_oe[l] = cap.cs && !mrdc_n && lane_en[l];
   end

   assign sd_out = mem[idx];

   // R8
   store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap.cs && !mwtc_q && mwtc_n) |=> $stable(mem));
endmodule

// File: rtl/isa_m16_slave.sv
module isa_m16_slave
   import isa_m16_pkg::*;
#(
   parameter logic [6:0] LA_BASE   = 7'h05,
   parameter logic [6:0] LA_MASK   = 7'h7F,
   parameter int         DEPTH     = 16,
   parameter bit         ZERO_WAIT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [6:0]  la_hi,
   input  logic [19:0] sa,
   input  logic        sbhe_n,
   input  logic        bale,
   input  logic        mrdc_n,
   input  logic        mwtc_n,
   input  logic [15:0] sd_in,
   input  logic        lcl_rdy,
   output logic [15:0] sd_out,
   output logic [1:0]  sd_oe,
   output logic        m16_n,
   output logic        nows_n,
   output logic        chrdy
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || $clog2(DEPTH) > SA_W - 1) begin : g_bad_depth
      $error("DEPTH must be a power of two within the SA window");
   end

   addr_cap_t cap;

   isa_m16_decode #(.LA_BASE(LA_BASE), .LA_MASK(LA_MASK)) u_decode (
      .clk(clk), .rst_n(rst_n), .la_hi(la_hi), .sa(sa), .sbhe_n(sbhe_n),
      .bale(bale), .cap(cap), .m16_n(m16_n));

   isa_m16_handshake #(.ZERO_WAIT(ZERO_WAIT)) u_hs (
      .clk(clk), .rst_n(rst_n), .cs(cap.cs), .mrdc_n(mrdc_n),
      .mwtc_n(mwtc_n), .lcl_rdy(lcl_rdy), .nows_n(nows_n), .chrdy(chrdy));

   isa_m16_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .cap(cap), .mrdc_n(mrdc_n), .mwtc_n(mwtc_n),
      .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

   // R7
   drive_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bale && (|sd_oe)) |-> !m16_n);
   // R9
   idle_when_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bale && m16_n) |-> (sd_oe == 2'b00 && chrdy && nows_n));
endmodule

// File: tb/isa_m16_slave_tb.sv
module isa_m16_slave_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        wr;
      logic [6:0]  la;
      logic [19:0] sa;
      logic        sbhe_n;
      logic [15:0] data;
      logic [1:0]  waits;
      logic        sel;
      logic [15:0] exp;
   } vec_t;

   localparam vec_t TABLE [8] = '{
      '{1'b1, 7'h05, 20'h00002, 1'b0, 16'hA1B2, 2'd0, 1'b1, 16'h0000},
      '{1'b1, 7'h05, 20'h00004, 1'b1, 16'h1234, 2'd2, 1'b1, 16'h0000},
      '{1'b1, 7'h05, 20'h00005, 1'b0, 16'h5600, 2'd0, 1'b1, 16'h0000},
      '{1'b1, 7'h06, 20'h00006, 1'b0, 16'hFFFF, 2'd1, 1'b0, 16'h0000},
      '{1'b0, 7'h05, 20'h00002, 1'b0, 16'h0000, 2'd0, 1'b1, 16'hA1B2},
      '{1'b0, 7'h05, 20'h00004, 1'b0, 16'h0000, 2'd1, 1'b1, 16'h5634},
      '{1'b0, 7'h05, 20'h00006, 1'b0, 16'h0000, 2'd0, 1'b1, 16'h0000},
      '{1'b0, 7'h06, 20'h00002, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h0000}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [6:0]  la_hi = '0;
   logic [19:0] sa = '0;
   logic sbhe_n = 1'b1, bale = 1'b0, mrdc_n = 1'b1, mwtc_n = 1'b1, lcl_rdy = 1'b1;
   logic [15:0] sd_in = '0, sd_out;
   logic [1:0]  sd_oe;
   logic m16_n, nows_n, chrdy;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isa_m16_slave u_dut (
      .clk(clk), .rst_n(rst_n), .la_hi(la_hi), .sa(sa), .sbhe_n(sbhe_n),
      .bale(bale), .mrdc_n(mrdc_n), .mwtc_n(mwtc_n), .sd_in(sd_in),
      .lcl_rdy(lcl_rdy), .sd_out(sd_out), .sd_oe(sd_oe), .m16_n(m16_n),
      .nows_n(nows_n), .chrdy(chrdy));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_cycle(input vec_t v);
      @(negedge clk);
      la_hi = v.la; sa = v.sa; sbhe_n = v.sbhe_n; bale = 1'b1;
      #2 chk("R2 m16 during bale", 32'(m16_n), 32'(!v.sel));
      @(negedge clk);
      bale = 1'b0; la_hi = v.la ^ 7'h7F; sa = v.sa ^ 20'h0000E; sbhe_n = 1'b1;
      #2 chk("R3 held select", 32'(m16_n), 32'(!v.sel));
      @(negedge clk);
      if (v.wr) begin mwtc_n = 1'b0; sd_in = v.data; end
      else mrdc_n = 1'b0;
      lcl_rdy = (v.waits == 0);
      for (int w = 0; w < int'(v.waits); w++) begin
         #2 chk("R6 wait inserted", 32'(chrdy), 32'(!v.sel));
         chk("R5 no zero-wait while waiting", 32'(nows_n), 32'd1);
         @(negedge clk);
         if (w == int'(v.waits) - 1) lcl_rdy = 1'b1;
      end
      #2 chk("R6 ready released", 32'(chrdy), 32'd1);
      chk("R5 zero-wait request", 32'(nows_n), 32'(!v.sel));
      if (v.wr) chk("R7 no drive on write", 32'(sd_oe), 32'd0);
      else begin
         chk("R7 R9 read lane enables", 32'(sd_oe), v.sel ? 32'd3 : 32'd0);
         if (v.sel) chk("R4 R8 R10 read data", 32'(sd_out), 32'(v.exp));
      end
      @(negedge clk);
      mwtc_n = 1'b1; mrdc_n = 1'b1;
      #2 chk("R5 R7 idle after command", 32'({sd_oe, nows_n}), 32'd1);
      @(negedge clk);
      sd_in = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 chk("R1 reset outputs", 32'({m16_n, nows_n, chrdy, sd_oe}), 32'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      #2 chk("R1 idle after reset", 32'({m16_n, nows_n, chrdy, sd_oe}), 32'b11100);
      // R1: last word of the store reads zero after reset
      run_cycle('{1'b0, 7'h05, 20'h0001E, 1'b0, 16'h0, 2'd0, 1'b1, 16'h0000});
      foreach (TABLE[i]) run_cycle(TABLE[i]);
      // R8: a write with the command held long, then read back
      run_cycle('{1'b1, 7'h05, 20'h00008, 1'b0, 16'hC3D4, 2'd2, 1'b1, 16'h0000});
      run_cycle('{1'b0, 7'h05, 20'h00008, 1'b0, 16'h0, 2'd0, 1'b1, 16'hC3D4});
      // R7: read of the odd byte enables only the high lane
      @(negedge clk);
      la_hi = 7'h05; sa = 20'h00003; sbhe_n = 1'b0; bale = 1'b1;
      @(negedge clk);
      bale = 1'b0; la_hi = 7'h00;
      @(negedge clk);
      mrdc_n = 1'b0;
      #2 chk("R7 high lane only", 32'(sd_oe), 32'd2);
      chk("R7 word data", 32'(sd_out), 32'hA1B2);
      @(negedge clk);
      mrdc_n = 1'b1;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule